// File: doc/BRIEF.md
# Signed/Unsigned Fractional Multiplier

A registered multiplier stage for a DSP datapath. Two 16-bit operands arrive, each with its own signed/unsigned select. Both are widened to 17 bits, so one signed 17 x 17 array serves signed, unsigned and mixed-sign products. The array produces a 33-bit core product. A scaler then shapes that product into a 40-bit word that fits an accumulator.

A mode input selects the output format:

- **Fractional:** the operands are read as Q15 values and the product is presented in 1.31 format.
- **Integer:** the plain product is returned. A size input picks word operands, which give a 32-bit result, or byte operands, which give a 16-bit result.

A one-cycle start strobe loads the result register, which holds its value until the next strobe. Rounding, accumulation and saturation belong to later stages. The one fractional overflow case, -1.0 x -1.0, is therefore passed on unclamped.

Top module: `dsp_mul17`

## Requirements
- R1: Each operand is widened to 17 bits before multiplying. A signed operand copies its sign bit into the new top bit, and an unsigned operand gets a zero there. In byte size the sign bit is operand bit 7.
- R2: In word integer mode (`frac_mode`=0, `byte_size`=0) the result is the 33-bit product sign-extended to 40 bits. Bits 31:0 hold the 32-bit product.
- R3: In fractional mode (`frac_mode`=1) the result is the sign-extended product shifted left by one bit. The radix point lies between bits 31 and 30, and result bit 0 is always 0.
- R4: In fractional mode with both operands signed, 0x8000 x 0x8000 yields 0x0080000000, which is +1.0 reaching into the guard bits. It is not clamped.
- R5: In byte integer mode (`frac_mode`=0, `byte_size`=1) only operand bits 7:0 are used. Bits 15:8 are ignored. The 16-bit product appears in result bits 15:0, and bits 39:16 are zero.
- R6: Mixed-sign products (one operand signed, the other unsigned) are exact in every size and mode.
- R7: When `frac_mode`=1, `byte_size` has no effect.
- R8: The result register loads on the rising clock edge at which `start` is high. While `start` is low it holds its value, whatever the inputs do.
- R9: A synchronous active-high `rst` clears the result to zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe for the result register |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_signed | input | 1 | 1: `op_a` is two's complement, 0: unsigned |
| b_signed | input | 1 | 1: `op_b` is two's complement, 0: unsigned |
| frac_mode | input | 1 | 1: Q15 x Q15 to 1.31, 0: integer |
| byte_size | input | 1 | Integer mode only. 1: byte operands, 0: word operands |
| result | output | 40 | Registered, sign-extended product |

## Verification
The assertions check several properties on every cycle:

- the result holds between strobes and clears after reset;
- fractional results carry a zero in bit 0;
- word integer results keep bits 39:32 equal to the sign;
- byte results keep bits 39:16 at zero;
- an unsigned x unsigned integer product is never negative;
- with both operands signed, a fractional spill into the guard bits comes only from -1.0 x -1.0, and that product gives exactly 0x0080000000.

Only the bench's vectors can show that the numeric values are right across sign combinations. That covers mixed-sign products, the Q15 boundary products, byte operands whose high bits are ignored, and fractional mode overriding the size select.

// File: rtl/dsp_mul17_pkg.sv
package dsp_mul17_pkg;
  localparam int DW = 16;          // operand width
  localparam int BW = 8;           // byte operand width
  localparam int EW = DW + 1;      // extended operand width
  localparam int PW = 2 * EW - 1;  // core product width
  localparam int OW = 40;          // accumulator-width output
  localparam int FB = 2 * DW - 1;  // fractional bits of 1.31 result
  localparam int RW = 2 * BW;      // byte-mode result width

  // Widen an operand to EW bits by its signedness; byte size uses bit BW-1.
  function automatic logic [EW-1:0] widen(input logic [DW-1:0] v,
                                          input logic sgn,
                                          input logic byt);
    logic [EW-1:0] w;
    if (byt)
      w = {{(EW-BW){sgn & v[BW-1]}}, v[BW-1:0]};
    else
      w = {sgn & v[DW-1], v};
    return w;
  endfunction

  // Signed product of two EW-bit values, PW bits wide.
  function automatic logic [PW-1:0] core_mul(input logic [EW-1:0] a,
                                             input logic [EW-1:0] b);
    logic signed [PW-1:0] sa;
    logic signed [PW-1:0] sb;
    sa = $signed({{(PW-EW){a[EW-1]}}, a});
    sb = $signed({{(PW-EW){b[EW-1]}}, b});
    return sa * sb;
  endfunction

  // Sign-extend the core product to the output width.
  function automatic logic [OW-1:0] sext_out(input logic [PW-1:0] p);
    return {{(OW-PW){p[PW-1]}}, p};
  endfunction
endpackage

// File: rtl/dm_opnd_ext.sv
module dm_opnd_ext
  import dsp_mul17_pkg::*;
(
  input  logic [DW-1:0] val,
  input  logic          is_signed,
  input  logic          byte_sel,
  output logic [EW-1:0] wide
);
  always_comb wide = widen(val, is_signed, byte_sel);
endmodule

// File: rtl/dm_mul_array.sv
module dm_mul_array
  import dsp_mul17_pkg::*;
(
  input  logic [EW-1:0] a_ext,
  input  logic [EW-1:0] b_ext,
  output logic [PW-1:0] prod
);
  always_comb prod = core_mul(a_ext, b_ext);
endmodule

// File: rtl/dm_scaler.sv
module dm_scaler
  import dsp_mul17_pkg::*;
(
  input  logic [PW-1:0] prod,
  input  logic          frac_mode,
  input  logic          byte_size,
  output logic [OW-1:0] scaled,
  output logic          guard_spill
);
  logic [OW-1:0] ext;

  always_comb begin
    ext = sext_out(prod);
    if (frac_mode)
      scaled = {ext[OW-2:0], 1'b0};
    else if (byte_size)
      scaled = {{(OW-RW){1'b0}}, prod[RW-1:0]};
    else
      scaled = ext;
  end

  // Fractional value no longer fits 1.31: guard bits differ from bit 31.
  always_comb
    guard_spill = frac_mode && (scaled[OW-1:FB+1] != {(OW-FB-1){scaled[FB]}});
endmodule

// File: rtl/dsp_mul17.sv
module dsp_mul17
  import dsp_mul17_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          a_signed,
  input  logic          b_signed,
  input  logic          frac_mode,
  input  logic          byte_size,
  output logic [OW-1:0] result
);
  logic [1:0][DW-1:0] ops;
  logic [1:0]         sgns;
  logic [1:0][EW-1:0] wides;
  logic               byte_eff;
  logic [PW-1:0]      prod33;
  logic [OW-1:0]      next_result;
  logic               guard_spill;

  assign ops      = {op_b, op_a};
  assign sgns     = {b_signed, a_signed};
  assign byte_eff = byte_size & ~frac_mode;   // fractional overrides size

  for (genvar i = 0; i < 2; i++) begin : g_ext
    dm_opnd_ext u_ext (
      .val       (ops[i]),
      .is_signed (sgns[i]),
      .byte_sel  (byte_eff),
      .wide      (wides[i])
    );
  end

  dm_mul_array u_arr (
    .a_ext (wides[0]),
    .b_ext (wides[1]),
    .prod  (prod33)
  );

  dm_scaler u_scl (
    .prod        (prod33),
    .frac_mode   (frac_mode),
    .byte_size   (byte_eff),
    .scaled      (next_result),
    .guard_spill (guard_spill)
  );

  always_ff @(posedge clk) begin
    if (rst)
      result <= '0;
    else if (start)
      result <= next_result;
  end
endmodule

// File: rtl/dsp_mul17_chk.sv
module dsp_mul17_chk
  import dsp_mul17_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          a_signed,
  input logic          b_signed,
  input logic          frac_mode,
  input logic          byte_size,
  input logic [OW-1:0] result,
  input logic          guard_spill
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> result == '0); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(result)); // R8
  AST_FRAC_LSB_ZERO: assert property (@(posedge clk) disable iff (rst) (start && frac_mode) |=> result[0] == 1'b0); // R3
  AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    (start && !frac_mode && !byte_size) |=> result[OW-1:FB+1] == {(OW-FB-1){result[FB+1]}}); // R2
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && !frac_mode && byte_size) |=> result[OW-1:RW] == '0); // R5
  AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (start && !frac_mode && !a_signed && !b_signed) |=> result[OW-1] == 1'b0); // R1
  AST_SPILL_ONLY_MIN: assert property (@(posedge clk) disable iff (rst)
    (frac_mode && a_signed && b_signed && guard_spill) |-> (op_a == 16'h8000 && op_b == 16'h8000)); // R4
  AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (rst)
    (start && frac_mode && a_signed && b_signed && op_a == 16'h8000 && op_b == 16'h8000)
    |=> result == 40'h0080000000); // R4
endmodule

bind dsp_mul17 dsp_mul17_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .op_a        (op_a),
  .op_b        (op_b),
  .a_signed    (a_signed),
  .b_signed    (b_signed),
  .frac_mode   (frac_mode),
  .byte_size   (byte_size),
  .result      (result),
  .guard_spill (guard_spill)
);

// File: tb/test_dsp_mul17.sv
module test_dsp_mul17;
  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        as_;
    logic        bs;
    logic        fr;
    logic        by;
    logic [39:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0003, 16'h0005, 1'b1, 1'b1, 1'b0, 1'b0, 40'h000000000F, 8'd2}, // R2
    '{16'hFFFF, 16'h0002, 1'b1, 1'b1, 1'b0, 1'b0, 40'hFFFFFFFFFE, 8'd2}, // R2
    '{16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00FFFE0001, 8'd1}, // R1
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 40'hFFFFFF0001, 8'd6}, // R6
    '{16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, 1'b0, 40'h0020000000, 8'd3}, // R3
    '{16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 40'h0080000000, 8'd4}, // R4
    '{16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b0, 40'hFF80010000, 8'd3}, // R3
    '{16'h12FE, 16'h3403, 1'b1, 1'b1, 1'b0, 1'b1, 40'h000000FFFA, 8'd5}, // R5
    '{16'hABFF, 16'hCDFF, 1'b0, 1'b0, 1'b0, 1'b1, 40'h000000FE01, 8'd5}, // R5
    '{16'h0080, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b1, 40'h0000008080, 8'd6}, // R6
    '{16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, 1'b1, 40'h0020000000, 8'd7}, // R7
    '{16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 40'h0040000000, 8'd2}, // R2
    '{16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b0, 1'b0, 40'hFFC0008000, 8'd1}  // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        a_signed = 1'b0;
  logic        b_signed = 1'b0;
  logic        frac_mode = 1'b0;
  logic        byte_size = 1'b0;
  logic [39:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dsp_mul17 i_dsp_mul17 (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .a_signed(a_signed), .b_signed(b_signed), .frac_mode(frac_mode),
    .byte_size(byte_size), .result(result)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: result=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b, input logic as_,
                      input logic bs, input logic fr, input logic by);
    @(negedge clk);
    op_a = a; op_b = b; a_signed = as_; b_signed = bs; frac_mode = fr; byte_size = by;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset state", result, 40'h0);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i].a, VECS[i].b, VECS[i].as_, VECS[i].bs, VECS[i].fr, VECS[i].by);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].expv);
    end

    // R8: inputs change without start; result must hold
    load(16'h0007, 16'h0009, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R8 load", result, 40'h000000003F);
    @(negedge clk);
    op_a = 16'h1234; op_b = 16'h8000; frac_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 hold without start", result, 40'h000000003F);

    // R8: no update before the strobe edge
    @(negedge clk);
    op_a = 16'h0002; op_b = 16'h0002; frac_mode = 1'b0; start = 1'b1;
    #1;
    check("R8 no early update", result, 40'h000000003F);
    @(negedge clk);
    start = 1'b0;
    check("R8 one-cycle latency", result, 40'h0000000004);

    // R5: byte mode ignores operand high bits
    load(16'hFF05, 16'h7F06, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 high byte ignored", result, 40'h000000001E);

    // R9: reset mid-run clears
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset clears", result, 40'h0);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      report();
    end
  end
endmodule